// File: doc/BRIEF.md
# Interrupt Pin Servicing Engine

This block is the per-pin core of a 24-input I/O interrupt controller. It holds a redirection entry for each pin, tracks a request bit (IRR) for every pin, and decides for each line assertion whether the interrupt is delivered or coalesced. A delivery is presented as one message on a valid/acknowledge handshake. The acknowledgement returns the number of destinations that accepted it. For level-triggered pins the block keeps a remote-IRR flag, which holds off further deliveries until an end-of-interrupt (EOI) for the pin's vector arrives.

Software or a bus front end writes the table one 32-bit half at a time. A line source reports level changes one event at a time. A local controller broadcasts EOIs that carry a vector. Each line event is answered with a one-cycle status pulse and an accepted count. A 256-bit map shows which vectors the table currently uses.

Top module: `irq_pin_engine`

## Requirements
- R1: After reset every entry has mask=1 and vector 0, all IRR and remote-IRR bits are 0, busy and dlv_valid are 0, and vec_map equals 1 (only bit 0 set).
- R2: A deasserting line event clears that pin's IRR bit and pulses evt_done one cycle later with status 0 (none). An asserting event always sets the IRR bit. Events that name a pin at or above NPINS are ignored.
- R3: An asserting event on an edge pin (low-word bit 15 = 0) whose IRR bit is already set returns status 1 (coalesced) and produces no delivery.
- R4: An asserting event on a level pin (low-word bit 15 = 1) whose remote IRR is set returns status 1 (coalesced) and produces no delivery.
- R5: An entry with mask set (low-word bit 16 = 1) is never delivered. An asserting event on such an entry that is not coalesced returns status 2 (masked) and leaves the IRR bit set.
- R6: A delivery message carries the pin number, the vector (low-word bits 7:0), the destination (high-word bits 31:24), the destination mode (low-word bit 11) and the trigger mode (bit 15). It also carries the 3-bit delivery mode (low-word bits 10:8) shifted left by 8 into an 11-bit field.
- R7: On acknowledgement, an edge pin's IRR bit clears. A level pin's remote IRR is set only if the accepted count is non-zero. The originating event then reports status 3 (delivered) with that count.
- R8: An EOI pulses ack_pulse, one cycle later, for every entry whose vector matches. A level EOI also clears remote IRR on those entries and re-services any of them whose IRR bit is set. An edge EOI leaves remote IRR unchanged.
- R9: Writing an entry's low half clears its remote IRR. After any write, a level entry whose IRR bit is set is re-serviced. An edge entry is not re-serviced.
- R10: vec_map has a bit set for the vector of each table entry, and it follows every table write.
- R11: When several pins await service, they are delivered one at a time, lowest pin number first.
- R12: While a delivery waits for acknowledgement, busy stays high and the message is held stable. Line, EOI and table inputs presented while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_valid | input | 1 | Line level event strobe |
| line_pin | input | PIN_W | Pin of the line event |
| line_level | input | 1 | New line level (1 = asserted) |
| tbl_we | input | 1 | Table half-word write strobe |
| tbl_pin | input | PIN_W | Entry being written |
| tbl_hi | input | 1 | 1 selects the high half, 0 the low half |
| tbl_data | input | 32 | Write data |
| eoi_valid | input | 1 | EOI broadcast strobe |
| eoi_vector | input | 8 | Vector carried by the EOI |
| eoi_level | input | 1 | 1 for a level EOI |
| dlv_ack | input | 1 | Delivery acknowledgement |
| dlv_accepted | input | CNT_W | Destinations that accepted the delivery |
| dlv_valid | output | 1 | Delivery message valid |
| dlv_pin | output | PIN_W | Pin being delivered |
| dlv_dest | output | 8 | Destination |
| dlv_vector | output | 8 | Vector |
| dlv_dest_mode | output | 1 | Destination mode |
| dlv_trig | output | 1 | Trigger mode, 1 = level |
| dlv_mode | output | 11 | Delivery mode shifted left by 8 |
| evt_done | output | 1 | Line event status pulse |
| evt_status | output | 2 | 0 none, 1 coalesced, 2 masked, 3 delivered |
| evt_count | output | CNT_W | Accepted count of the event's delivery |
| ack_pulse | output | NPINS | Per-pin EOI acknowledgement pulses |
| irr_o | output | NPINS | Interrupt request bits |
| rirr_o | output | NPINS | Remote IRR bits |
| vec_map | output | 256 | Vectors used by the table |
| busy | output | 1 | Engine is servicing or waiting |

## Verification
Some rules are checked by the assertions on every cycle. A message is held stable until it is acknowledged. A masked entry never appears on the delivery port. The delivery mode always lands in bits 10:8. An acknowledgement clears the IRR bit of an edge pin, or sets the remote IRR of a level pin. Coalescing on the IRR bit or on remote IRR is also checked. Other behaviour can only be shown by the bench's scenarios. These are the ordering of several re-serviced pins after an EOI, the difference between edge and level EOIs, a remote IRR cleared by a table write, the way a masked pin keeps its request, and the contents of the vector map.

// File: rtl/irq_pin_engine.sv
module irq_pin_engine #(
  parameter int NPINS = 24,
  parameter int CNT_W = 8,
  localparam int PIN_W = $clog2(NPINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_valid,
  input  logic [PIN_W-1:0]  line_pin,
  input  logic              line_level,
  input  logic              tbl_we,
  input  logic [PIN_W-1:0]  tbl_pin,
  input  logic              tbl_hi,
  input  logic [31:0]       tbl_data,
  input  logic              eoi_valid,
  input  logic [7:0]        eoi_vector,
  input  logic              eoi_level,
  input  logic              dlv_ack,
  input  logic [CNT_W-1:0]  dlv_accepted,
  output logic              dlv_valid,
  output logic [PIN_W-1:0]  dlv_pin,
  output logic [7:0]        dlv_dest,
  output logic [7:0]        dlv_vector,
  output logic              dlv_dest_mode,
  output logic              dlv_trig,
  output logic [10:0]       dlv_mode,
  output logic              evt_done,
  output logic [1:0]        evt_status,
  output logic [CNT_W-1:0]  evt_count,
  output logic [NPINS-1:0]  ack_pulse,
  output logic [NPINS-1:0]  irr_o,
  output logic [NPINS-1:0]  rirr_o,
  output logic [255:0]      vec_map,
  output logic              busy
);
  localparam logic [PIN_W:0] NP = (PIN_W+1)'(NPINS);
  localparam logic [1:0] ST_NONE = 2'd0, ST_COAL = 2'd1, ST_MASK = 2'd2, ST_DLV = 2'd3;

  logic [7:0]       t_vec  [NPINS];
  logic [7:0]       t_dest [NPINS];
  logic [2:0]       t_mode [NPINS];
  logic [NPINS-1:0] t_dm, t_lvl, t_mask;
  logic [NPINS-1:0] irr, rirr, svc_req;
  logic             waiting, evt_pend;
  logic [PIN_W-1:0] evt_pin;

  logic unused_bits;
  assign unused_bits = ^{tbl_data[31:17], tbl_data[14:12]};

  assign dlv_valid = waiting;
  assign busy      = waiting | (|svc_req) | evt_pend;
  assign irr_o     = irr;
  assign rirr_o    = rirr;

  wire line_go = !busy && line_valid && ({1'b0, line_pin} < NP);
  wire eoi_go  = !busy && !line_valid && eoi_valid;
  wire tbl_go  = !busy && !line_valid && !eoi_valid && tbl_we && ({1'b0, tbl_pin} < NP);

  wire l_coal    = t_lvl[line_pin] ? rirr[line_pin] : irr[line_pin];
  wire w_new_lvl = tbl_hi ? t_lvl[tbl_pin] : tbl_data[15];

  logic             sel_ok;
  logic [PIN_W-1:0] sel;
  always_comb begin
    sel_ok = 1'b0;
    sel    = '0;
    for (int i = NPINS-1; i >= 0; i--)
      if (svc_req[i]) begin
        sel_ok = 1'b1;
        sel    = PIN_W'(i);
      end
  end

  always_comb begin
    vec_map = '0;
    for (int i = 0; i < NPINS; i++) vec_map[t_vec[i]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPINS; i++) begin
        t_vec[i]  <= '0;
        t_dest[i] <= '0;
        t_mode[i] <= '0;
      end
      t_dm <= '0; t_lvl <= '0; t_mask <= '1;
      irr <= '0; rirr <= '0; svc_req <= '0;
      waiting <= 1'b0; evt_pend <= 1'b0; evt_pin <= '0;
      dlv_pin <= '0; dlv_dest <= '0; dlv_vector <= '0;
      dlv_dest_mode <= 1'b0; dlv_trig <= 1'b0; dlv_mode <= '0;
      evt_done <= 1'b0; evt_status <= ST_NONE; evt_count <= '0;
      ack_pulse <= '0;
    end else begin
      evt_done  <= 1'b0;
      ack_pulse <= '0;

      if (line_go) begin
        if (!line_level) begin
          irr[line_pin] <= 1'b0;
          evt_done      <= 1'b1;
          evt_status    <= ST_NONE;
          evt_count     <= '0;
        end else begin
          irr[line_pin] <= 1'b1;
          if (l_coal) begin
            evt_done   <= 1'b1;
            evt_status <= ST_COAL;
            evt_count  <= '0;
          end else if (t_mask[line_pin]) begin
            evt_done   <= 1'b1;
            evt_status <= ST_MASK;
            evt_count  <= '0;
          end else begin
            svc_req[line_pin] <= 1'b1;
            evt_pend          <= 1'b1;
            evt_pin           <= line_pin;
          end
        end
      end

      if (eoi_go)
        for (int i = 0; i < NPINS; i++)
          if (t_vec[i] == eoi_vector) begin
            ack_pulse[i] <= 1'b1;
            if (eoi_level) begin
              rirr[i] <= 1'b0;
              if (irr[i]) svc_req[i] <= 1'b1;
            end
          end

      if (tbl_go) begin
        if (tbl_hi) begin
          t_dest[tbl_pin] <= tbl_data[31:24];
        end else begin
          t_vec[tbl_pin]  <= tbl_data[7:0];
          t_mode[tbl_pin] <= tbl_data[10:8];
          t_dm[tbl_pin]   <= tbl_data[11];
          t_lvl[tbl_pin]  <= tbl_data[15];
          t_mask[tbl_pin] <= tbl_data[16];
          rirr[tbl_pin]   <= 1'b0;
        end
        if (w_new_lvl && irr[tbl_pin]) svc_req[tbl_pin] <= 1'b1;
      end

      if (!waiting && sel_ok) begin
        svc_req[sel] <= 1'b0;
        if (!t_mask[sel]) begin
          waiting       <= 1'b1;
          dlv_pin       <= sel;
          dlv_dest      <= t_dest[sel];
          dlv_vector    <= t_vec[sel];
          dlv_dest_mode <= t_dm[sel];
          dlv_trig      <= t_lvl[sel];
          dlv_mode      <= {t_mode[sel], 8'h00};
        end else if (evt_pend && evt_pin == sel) begin
          evt_pend   <= 1'b0;
          evt_done   <= 1'b1;
          evt_status <= ST_MASK;
          evt_count  <= '0;
        end
      end

      if (waiting && dlv_ack) begin
        waiting <= 1'b0;
        if (!dlv_trig) irr[dlv_pin] <= 1'b0;
        else if (dlv_accepted != '0) rirr[dlv_pin] <= 1'b1;
        if (evt_pend && evt_pin == dlv_pin) begin
          evt_pend   <= 1'b0;
          evt_done   <= 1'b1;
          evt_status <= ST_DLV;
          evt_count  <= dlv_accepted;
        end
      end
    end
  end

  AST_EDGE_COAL: assert property (@(posedge clk) disable iff (!rst_n)
    line_go && line_level && !t_lvl[line_pin] && irr[line_pin] |=> evt_done && evt_status == ST_COAL); // R3
  AST_LEVEL_COAL: assert property (@(posedge clk) disable iff (!rst_n)
    line_go && line_level && t_lvl[line_pin] && rirr[line_pin] |=> evt_done && evt_status == ST_COAL); // R4
  AST_NO_MASKED_DLV: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> !t_mask[dlv_pin]); // R5
  AST_MODE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> dlv_mode[7:0] == 8'h00); // R6
  AST_EDGE_IRR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && dlv_ack && !dlv_trig |=> !irr[$past(dlv_pin)]); // R7
  AST_LEVEL_RIRR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && dlv_ack && dlv_trig && dlv_accepted != '0 |=> rirr[$past(dlv_pin)]); // R7
  AST_HOLD_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && !dlv_ack |=> dlv_valid && $stable(dlv_pin) && $stable(dlv_vector) && $stable(dlv_dest)); // R12
  AST_BUSY_DLV: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> busy); // R12
endmodule

// File: tb/irq_pin_engine_test.sv
module irq_pin_engine_test;
  localparam int NPINS = 24;
  localparam int CNT_W = 8;
  localparam int PIN_W = $clog2(NPINS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_valid = 0, line_level = 0, tbl_we = 0, tbl_hi = 0;
  logic eoi_valid = 0, eoi_level = 0, dlv_ack = 0;
  logic [PIN_W-1:0] line_pin = '0, tbl_pin = '0;
  logic [31:0] tbl_data = '0;
  logic [7:0] eoi_vector = '0;
  logic [CNT_W-1:0] dlv_accepted = '0;
  logic dlv_valid, dlv_dest_mode, dlv_trig, evt_done, busy;
  logic [PIN_W-1:0] dlv_pin;
  logic [7:0] dlv_dest, dlv_vector;
  logic [10:0] dlv_mode;
  logic [1:0] evt_status;
  logic [CNT_W-1:0] evt_count;
  logic [NPINS-1:0] ack_pulse, irr_o, rirr_o;
  logic [255:0] vec_map;

  always #5 clk = ~clk;

  irq_pin_engine #(.NPINS(NPINS), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .line_valid(line_valid), .line_pin(line_pin), .line_level(line_level),
    .tbl_we(tbl_we), .tbl_pin(tbl_pin), .tbl_hi(tbl_hi), .tbl_data(tbl_data),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_level(eoi_level),
    .dlv_ack(dlv_ack), .dlv_accepted(dlv_accepted),
    .dlv_valid(dlv_valid), .dlv_pin(dlv_pin), .dlv_dest(dlv_dest), .dlv_vector(dlv_vector),
    .dlv_dest_mode(dlv_dest_mode), .dlv_trig(dlv_trig), .dlv_mode(dlv_mode),
    .evt_done(evt_done), .evt_status(evt_status), .evt_count(evt_count),
    .ack_pulse(ack_pulse), .irr_o(irr_o), .rirr_o(rirr_o), .vec_map(vec_map), .busy(busy));

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  bit got_dlv, got_done;
  logic [1:0] r_st;
  logic [7:0] r_cnt, d_vec, d_dest;
  logic [PIN_W-1:0] d_pin;
  logic d_dm, d_trig;
  logic [10:0] d_mode;
  logic [NPINS-1:0] r_ack;
  int seq [8];
  int nseq;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lo(input logic [7:0] vec, input logic [2:0] mode,
                                     input bit dm, input bit lvl, input bit msk);
    return {15'b0, msk, lvl, 3'b000, dm, mode, vec};
  endfunction

  task automatic serve(input int cnt);
    for (int k = 0; k < 40; k++) begin
      if (dlv_valid) begin
        if (nseq < 8) seq[nseq] = int'(dlv_pin);
        nseq++;
        got_dlv = 1;
        d_pin = dlv_pin; d_vec = dlv_vector; d_dest = dlv_dest;
        d_dm = dlv_dest_mode; d_trig = dlv_trig; d_mode = dlv_mode;
        dlv_ack = 1; dlv_accepted = CNT_W'(cnt);
        @(negedge clk);
        dlv_ack = 0;
      end else if (!busy) break;
      else @(negedge clk);
    end
  endtask

  task automatic wr(input int pin, input bit hi, input logic [31:0] d, input int cnt);
    @(negedge clk);
    tbl_we = 1; tbl_pin = PIN_W'(pin); tbl_hi = hi; tbl_data = d;
    @(negedge clk);
    tbl_we = 0;
    nseq = 0; got_dlv = 0;
    serve(cnt);
  endtask

  task automatic line_evt(input int pin, input bit lvl, input int cnt);
    got_dlv = 0; got_done = 0; nseq = 0;
    @(negedge clk);
    line_valid = 1; line_pin = PIN_W'(pin); line_level = lvl;
    @(negedge clk);
    line_valid = 0;
    for (int k = 0; k < 20 && !got_done; k++) begin
      if (evt_done) begin
        got_done = 1; r_st = evt_status; r_cnt = evt_count;
      end else if (dlv_valid) begin
        got_dlv = 1;
        d_pin = dlv_pin; d_vec = dlv_vector; d_dest = dlv_dest;
        d_dm = dlv_dest_mode; d_trig = dlv_trig; d_mode = dlv_mode;
        dlv_ack = 1; dlv_accepted = CNT_W'(cnt);
        @(negedge clk);
        dlv_ack = 0;
      end else @(negedge clk);
    end
  endtask

  task automatic eoi(input logic [7:0] v, input bit lvl, input int cnt);
    @(negedge clk);
    eoi_valid = 1; eoi_vector = v; eoi_level = lvl;
    @(negedge clk);
    eoi_valid = 0;
    r_ack = ack_pulse;
    nseq = 0; got_dlv = 0;
    serve(cnt);
  endtask

  task automatic t_reset();
    chk(irr_o == 0, "R1 irr", 64'(irr_o), 0);
    chk(rirr_o == 0, "R1 rirr", 64'(rirr_o), 0);
    chk(!busy && !dlv_valid, "R1 busy/dlv", {busy, dlv_valid}, 0);
    chk(vec_map == 256'h1, "R1 vec_map", vec_map[63:0], 1);
    line_evt(5, 1, 1);
    chk(r_st == 2'd2 && !got_dlv, "R1 reset entries masked", r_st, 2);
    line_evt(5, 0, 0);
  endtask

  task automatic t_edge();
    wr(3, 1, 32'h0A00_0000, 0);
    wr(3, 0, lo(8'h41, 3'b101, 1, 0, 0), 0);
    chk(vec_map[8'h41] && vec_map[0], "R10 map after write", vec_map[65:64], 2'b11);
    line_evt(3, 1, 2);
    chk(got_dlv && d_pin == 3 && d_vec == 8'h41 && d_dest == 8'h0A, "R6 msg fields",
        {d_pin, d_vec, d_dest}, {5'd3, 8'h41, 8'h0A});
    chk(d_dm == 1 && d_trig == 0 && d_mode == 11'h500, "R6 mode shift",
        {d_dm, d_trig, d_mode}, {2'b10, 11'h500});
    chk(got_done && r_st == 2'd3 && r_cnt == 2, "R7 delivered status", {r_st, r_cnt}, {2'd3, 8'd2});
    chk(irr_o[3] == 0, "R7 edge irr cleared", irr_o[3], 0);
    line_evt(3, 0, 0);
    chk(got_done && r_st == 2'd0 && irr_o[3] == 0, "R2 deassert", {r_st, irr_o[3]}, 0);
    line_evt(30, 1, 0);
    chk(!got_done && !got_dlv && irr_o == 0, "R2 out-of-range pin ignored", 64'(irr_o), 0);
  endtask

  task automatic t_masked();
    wr(4, 0, lo(8'h50, 3'b000, 0, 0, 1), 0);
    line_evt(4, 1, 1);
    chk(r_st == 2'd2 && !got_dlv && irr_o[4], "R5 masked keeps irr", {r_st, irr_o[4]}, {2'd2, 1'b1});
    line_evt(4, 1, 1);
    chk(r_st == 2'd1 && !got_dlv, "R3 edge coalesced", r_st, 1);
    wr(4, 0, lo(8'h50, 3'b000, 0, 0, 0), 1);
    chk(!got_dlv && irr_o[4], "R9 edge entry not reserviced", {got_dlv, irr_o[4]}, 1);
    line_evt(4, 0, 0);
    chk(irr_o[4] == 0, "R2 irr cleared", irr_o[4], 0);
  endtask

  task automatic t_level();
    wr(6, 1, 32'h0300_0000, 0);
    wr(6, 0, lo(8'h60, 3'b001, 0, 1, 0), 0);
    line_evt(6, 1, 1);
    chk(got_dlv && d_trig && r_st == 2'd3 && rirr_o[6] && irr_o[6], "R7 level rirr set",
        {d_trig, r_st, rirr_o[6], irr_o[6]}, {1'b1, 2'd3, 2'b11});
    line_evt(6, 1, 1);
    chk(r_st == 2'd1 && !got_dlv, "R4 level coalesced", r_st, 1);
    eoi(8'h60, 0, 1);
    chk(r_ack == (NPINS'(1) << 6) && rirr_o[6] && !got_dlv, "R8 edge eoi",
        {40'(r_ack), rirr_o[6]}, {40'(NPINS'(1) << 6), 1'b1});
    eoi(8'h60, 1, 1);
    chk(r_ack[6] && got_dlv && d_pin == 6 && rirr_o[6], "R8 level eoi reservice",
        {r_ack[6], got_dlv, rirr_o[6]}, 3'b111);
    line_evt(6, 0, 0);
    eoi(8'h60, 1, 1);
    chk(!got_dlv && rirr_o[6] == 0, "R8 eoi clears rirr", rirr_o[6], 0);
  endtask

  task automatic t_write();
    wr(7, 0, lo(8'h70, 3'b000, 0, 1, 0), 0);
    line_evt(7, 1, 0);
    chk(r_st == 2'd3 && r_cnt == 0 && rirr_o[7] == 0, "R7 zero count no rirr",
        {r_st, rirr_o[7]}, {2'd3, 1'b0});
    wr(7, 1, 32'h0500_0000, 1);
    chk(got_dlv && d_pin == 7 && d_dest == 8'h05 && rirr_o[7], "R9 level write reservice",
        {got_dlv, d_dest, rirr_o[7]}, {1'b1, 8'h05, 1'b1});
    wr(7, 0, lo(8'h70, 3'b000, 0, 1, 1), 1);
    chk(!got_dlv && rirr_o[7] == 0 && irr_o[7], "R9 low write clears rirr",
        {got_dlv, rirr_o[7], irr_o[7]}, 3'b001);
    chk(vec_map[8'h70] && vec_map[8'h60], "R10 map bits", {vec_map[8'h70], vec_map[8'h60]}, 2'b11);
    wr(7, 0, lo(8'h71, 3'b000, 0, 1, 1), 0);
    chk(!vec_map[8'h70] && vec_map[8'h71], "R10 map follows rewrite",
        {vec_map[8'h70], vec_map[8'h71]}, 2'b01);
    line_evt(7, 0, 0);
  endtask

  task automatic t_prio();
    wr(9, 0, lo(8'h90, 3'b000, 0, 1, 0), 0);
    wr(2, 0, lo(8'h90, 3'b000, 0, 1, 0), 0);
    line_evt(9, 1, 1);
    line_evt(2, 1, 1);
    chk(rirr_o[9] && rirr_o[2], "R7 both rirr", {rirr_o[9], rirr_o[2]}, 2'b11);
    eoi(8'h90, 1, 1);
    chk(r_ack == ((NPINS'(1) << 9) | (NPINS'(1) << 2)), "R8 ack both", 64'(r_ack),
        64'((NPINS'(1) << 9) | (NPINS'(1) << 2)));
    chk(nseq == 2 && seq[0] == 2 && seq[1] == 9, "R11 lowest first",
        {8'(nseq), 8'(seq[0]), 8'(seq[1])}, {8'd2, 8'd2, 8'd9});
    line_evt(9, 0, 0);
    line_evt(2, 0, 0);
    eoi(8'h90, 1, 0);
  endtask

  task automatic t_busy();
    bit stable_ok = 1;
    wr(10, 0, lo(8'hA0, 3'b010, 0, 0, 0), 0);
    wr(11, 0, lo(8'hB0, 3'b000, 0, 0, 0), 0);
    @(negedge clk);
    line_valid = 1; line_pin = 5'd10; line_level = 1;
    @(negedge clk);
    line_valid = 0;
    @(negedge clk);
    chk(dlv_valid && busy && dlv_vector == 8'hA0, "R12 waiting", {dlv_valid, busy, dlv_vector},
        {2'b11, 8'hA0});
    line_valid = 1; line_pin = 5'd11; line_level = 1;
    @(negedge clk);
    line_valid = 0;
    for (int k = 0; k < 4; k++) begin
      if (!(dlv_valid && busy && dlv_pin == 10 && dlv_mode == 11'h200)) stable_ok = 0;
      @(negedge clk);
    end
    chk(stable_ok, "R12 message held", {dlv_pin, dlv_mode}, {5'd10, 11'h200});
    chk(irr_o[11] == 0, "R12 input ignored while busy", irr_o[11], 0);
    dlv_ack = 1; dlv_accepted = 8'd3;
    @(negedge clk);
    dlv_ack = 0;
    chk(evt_done && evt_status == 2'd3 && evt_count == 3 && !busy, "R7 late ack status",
        {evt_status, evt_count}, {2'd3, 8'd3});
    line_evt(10, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_edge();
    t_masked();
    t_level();
    t_write();
    t_prio();
    t_busy();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule